// File: doc/BRIEF.md
# Multichannel Scaling Time-Bin Counter

This block gathers a count-versus-time record. Once armed, it counts qualifying events for a fixed dwell period and writes the total into the current time channel of a spectrum memory. It then opens the next channel at once and repeats this until the selected number of channels has been filled. In continuous-sweep mode it wraps back to channel zero and keeps going until it is stopped.

Events come from one of three sources. The first is an external logic-level pulse line, synchronized and counted on its rising edge without passing through the converter. The second is the converter's result strobe, counted only when its channel code lies inside a programmable digital window. The third is the amplifier's input-count-rate strobe. The dwell period is a whole number of 10 µs ticks taken from a prescaler, and a 26-bit tick count reaches 500 s. Three write-only registers hold the configuration. Start and stop inputs control the acquisition, and a single write port feeds the spectrum memory.

Top module: `mcs_binner`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are all low.
- R2: In pulse-line mode, each low-to-high transition of `ttl_in` adds exactly one count, and a level held high for any number of cycles still adds only one.
- R3: In window mode, a strobed code counts when lower <= code <= upper, with both limits inclusive. If upper is below lower, nothing counts. Register 1 holds lower in bits [CODE_W-1:0] and upper in bits [16+CODE_W-1:16].
- R4: Register 0 bits [1:0] select the source: 0 is the pulse line, 1 is the code window, 2 is the rate strobe and 3 is none. Activity on any source that is not selected never changes a stored count.
- R5: Each channel spans TICK_DIV × N clock cycles, where N is held in register 2 bits [DWELL_W-1:0]. A value of N = 0 behaves as N = 1.
- R6: No event is lost at a channel boundary. An event counted on the closing cycle goes into the channel being written, so a source that is active on every cycle yields exactly TICK_DIV × N in every channel.
- R7: The channel count is 128 << k, where k is held in register 0 bits [4:2]. Any k >= 5 selects 4096. Writes go to ascending addresses, starting at 0.
- R8: Without sweep mode, `done` rises together with the write of the last channel, `busy` falls, and no further write follows. A `start` pulse clears `done` and restarts from channel 0.
- R9: When register 0 bit 5 is set, the write after the last channel goes to address 0, and acquisition continues with the same dwell.
- R10: A channel count saturates at all ones and does not wrap.
- R11: A `stop` pulse drops `busy` on the next cycle, discards the partial channel without writing it, and leaves `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 window, 2 dwell |
| reg_wdata | input | 32 | Register write data |
| start | input | 1 | Arm and restart from channel 0 |
| stop | input | 1 | Abort acquisition |
| ttl_in | input | 1 | Asynchronous external pulse line |
| adc_valid | input | 1 | Converter result strobe |
| adc_code | input | CODE_W | Converter channel code |
| icr_strobe | input | 1 | Amplifier input-count-rate strobe |
| mem_we | output | 1 | Spectrum memory write enable |
| mem_addr | output | 12 | Time channel being written |
| mem_data | output | CNT_W | Count for that channel |
| busy | output | 1 | Acquisition running |
| done | output | 1 | One-shot sweep completed |

## Verification
A corrupt event pipeline or window compare appears as a wrong `mem_data` on the first memory write after the fault, which is at most one dwell period later. A broken address counter or channel-length decode shows as a write to an unexpected address, or as a missing or extra write near the final channel. A dwell timer that is off by even one cycle changes the total of every channel while the rate source is held active. A faulty run/stop state shows as writes after `busy` has fallen or as a `done` flag with no final write.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    SRC_TTL  = 2'd0,
    SRC_WIN  = 2'd1,
    SRC_ICR  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  localparam int MIN_CH   = 128;
  localparam int MAX_K    = 5;
  localparam int ADDR_W   = $clog2(MIN_CH) + MAX_K;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_WIN   = 2'd1;
  localparam logic [1:0] SEL_DWELL = 2'd2;
endpackage

// File: rtl/mcs_cfg_regs.sv
module mcs_cfg_regs
  import mcs_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int DWELL_W = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [1:0]         sel,
  input  logic [31:0]        wdata,
  output src_e               src,
  output logic [2:0]         len_k,
  output logic               sweep,
  output logic [CODE_W-1:0]  win_lo,
  output logic [CODE_W-1:0]  win_hi,
  output logic [DWELL_W-1:0] dwell_n
);
  wire unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      src     <= SRC_TTL;
      len_k   <= '0;
      sweep   <= 1'b0;
      win_lo  <= '0;
      win_hi  <= '1;
      dwell_n <= DWELL_W'(1);
    end else if (we) begin
      case (sel)
        SEL_CTRL: begin
          src   <= src_e'(wdata[1:0]);
          len_k <= wdata[4:2];
          sweep <= wdata[5];
        end
        SEL_WIN: begin
          win_lo <= wdata[CODE_W-1:0];
          win_hi <= wdata[16 +: CODE_W];
        end
        SEL_DWELL: dwell_n <= wdata[DWELL_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcs_event_sel.sv
module mcs_event_sel
  import mcs_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  src_e              src,
  input  logic              ttl_in,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [CODE_W-1:0] win_lo,
  input  logic [CODE_W-1:0] win_hi,
  input  logic              icr_strobe,
  output logic              ev
);
  localparam int SH_W = SYNC_N + 1;

  logic [SH_W-1:0] ttl_sh;
  logic            ttl_rise;
  logic            in_win;
  logic            ev_d;

  assign ttl_rise = ttl_sh[SH_W-2] & ~ttl_sh[SH_W-1];
  assign in_win   = adc_valid && (adc_code >= win_lo) && (adc_code <= win_hi);

  always_comb begin
    case (src)
      SRC_TTL: ev_d = ttl_rise;
      SRC_WIN: ev_d = in_win;
      SRC_ICR: ev_d = icr_strobe;
      default: ev_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ttl_sh <= '0;
      ev     <= 1'b0;
    end else begin
      ttl_sh <= {ttl_sh[SH_W-2:0], ttl_in};
      ev     <= ev_d;
    end
  end
endmodule

// File: rtl/mcs_dwell_timer.sv
module mcs_dwell_timer #(
  parameter int TICK_DIV = 1250,
  parameter int DWELL_W  = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               run,
  input  logic [DWELL_W-1:0] dwell_n,
  output logic               bound
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0]      presc;
  logic [DWELL_W-1:0] dcnt;
  logic [DWELL_W-1:0] term_m1;
  logic               tick;
  logic               dlast;

  assign tick    = (presc == PW'(TICK_DIV - 1));
  assign term_m1 = (dwell_n == '0) ? '0 : dwell_n - 1'b1;
  assign dlast   = (dcnt >= term_m1);
  assign bound   = run && tick && dlast;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      presc <= '0;
      dcnt  <= '0;
    end else if (run) begin
      presc <= tick ? '0 : presc + 1'b1;
      if (tick) dcnt <= dlast ? '0 : dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/mcs_binner.sv
module mcs_binner
  import mcs_pkg::*;
#(
  parameter int TICK_DIV = 1250,
  parameter int DWELL_W  = 26,
  parameter int CODE_W   = 12,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              start,
  input  logic              stop,
  input  logic              ttl_in,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic              icr_strobe,
  output logic              mem_we,
  output logic [11:0]       mem_addr,
  output logic [CNT_W-1:0]  mem_data,
  output logic              busy,
  output logic              done
);
  src_e               src;
  logic [2:0]         len_k;
  logic               sweep;
  logic [CODE_W-1:0]  win_lo;
  logic [CODE_W-1:0]  win_hi;
  logic [DWELL_W-1:0] dwell_n;
  logic               ev;
  logic               bound;
  logic [ADDR_W-1:0]  addr;
  logic [ADDR_W-1:0]  last_addr;
  logic [ADDR_W:0]    nch;
  logic [2:0]         k_eff;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   count_nxt;

  mcs_cfg_regs #(.CODE_W(CODE_W), .DWELL_W(DWELL_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .src(src), .len_k(len_k), .sweep(sweep),
    .win_lo(win_lo), .win_hi(win_hi), .dwell_n(dwell_n)
  );

  mcs_event_sel #(.CODE_W(CODE_W)) u_evsel (
    .clk(clk), .rst(rst), .src(src), .ttl_in(ttl_in),
    .adc_valid(adc_valid), .adc_code(adc_code),
    .win_lo(win_lo), .win_hi(win_hi), .icr_strobe(icr_strobe), .ev(ev)
  );

  mcs_dwell_timer #(.TICK_DIV(TICK_DIV), .DWELL_W(DWELL_W)) u_timer (
    .clk(clk), .rst(rst), .clear(start),
    .run(busy && !start && !stop), .dwell_n(dwell_n), .bound(bound)
  );

  assign k_eff     = (len_k > 3'(MAX_K)) ? 3'(MAX_K) : len_k;
  assign nch       = (ADDR_W+1)'(MIN_CH) << k_eff;
  assign last_addr = ADDR_W'(nch - 1'b1);
  assign count_nxt = (ev && !(&count)) ? count + 1'b1 : count;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      count    <= '0;
      addr     <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        count <= '0;
        addr  <= '0;
      end else if (stop) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (bound) begin
          mem_we   <= 1'b1;
          mem_addr <= addr;
          mem_data <= count_nxt;
          count    <= '0;
          if (addr == last_addr) begin
            addr <= '0;
            if (!sweep) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end else begin
            addr <= addr + 1'b1;
          end
        end else begin
          count <= count_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/mcs_binner_chk.sv
module mcs_binner_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (mem_we) begin
      have_prev <= 1'b1;
      prev_addr <= mem_addr;
    end
  end

  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && have_prev) |-> (mem_addr == prev_addr + 1'b1) || (mem_addr == '0));

  p_first_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !have_prev) |-> (mem_addr == '0));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_write_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> mem_we);

  p_start_arm_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !done));

  p_idle_nowrite_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !mem_we);
endmodule

bind mcs_binner mcs_binner_chk #(.ADDR_W(mcs_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mem_we(mem_we),
  .mem_addr(mem_addr), .busy(busy), .done(done)
);

// File: tb/test_mcs_binner.sv
`timescale 1ns/1ps
module test_mcs_binner;
  localparam int TD     = 4;
  localparam int CW     = 12;
  localparam int NW     = 8;

  typedef struct {
    int    addr;
    int    data;
    string req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic          ttl_in = 1'b0;
  logic          adc_valid = 1'b0;
  logic [CW-1:0] adc_code = '0;
  logic          icr_strobe = 1'b0;
  logic          mem_we;
  logic [11:0]   mem_addr;
  logic [NW-1:0] mem_data;
  logic          busy;
  logic          done;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  item_t q[$];

  always #4 clk = ~clk;

  mcs_binner #(.TICK_DIV(TD), .CODE_W(CW), .CNT_W(NW)) i_mcs_binner (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .start(start), .stop(stop), .ttl_in(ttl_in),
    .adc_valid(adc_valid), .adc_code(adc_code), .icr_strobe(icr_strobe),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected writes as the design produces them
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (q.size() == 0) begin
        check(1'b0, "R8/R11 unexpected write addr", int'(mem_addr), -1);
      end else begin
        item_t it;
        it = q.pop_front();
        check(int'(mem_addr) == it.addr, {it.req, " addr"}, int'(mem_addr), it.addr);
        check(int'(mem_data) == it.data, {it.req, " data"}, int'(mem_data), it.data);
      end
    end
  end

  task automatic expect_bins(input int first, input int n, input int data, input string req);
    for (int i = 0; i < n; i++) q.push_back('{addr: (first + i) % 4096, data: data, req: req});
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic drain(input int lim, input string req);
    int n = 0;
    while (q.size() != 0 && n < lim) begin
      @(negedge clk);
      n++;
    end
    check(q.size() == 0, {req, " missing writes"}, q.size(), 0);
    q.delete();
  endtask

  task automatic send_code(input int c);
    @(negedge clk); adc_valid = 1'b1; adc_code = CW'(c);
    @(negedge clk); adc_valid = 1'b0;
  endtask

  task automatic ttl_pulse(input int hi, input int lo);
    @(negedge clk); ttl_in = 1'b1;
    repeat (hi) @(negedge clk);
    ttl_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic idle_check(input string req);
    check(busy == 1'b0, {req, " busy after stop"}, int'(busy), 0);
    check(done == 1'b0, {req, " done after stop"}, int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_we == 1'b0, "R1 after release", int'(busy), 0);

    // R6/R7/R8: rate source on every cycle, N=2, 128 channels, one-shot
    wr_reg(2'd2, 32'd2);
    wr_reg(2'd0, 32'h2);
    icr_strobe = 1'b1;
    expect_bins(0, 128, 2 * TD, "R6");
    pulse_start();
    drain(3000, "R7");
    check(done == 1'b1, "R8 done set", int'(done), 1);
    check(busy == 1'b0, "R8 busy clear", int'(busy), 0);
    repeat (40) @(negedge clk);

    // R5 N=0 behaves as 1, R7 k=1 gives 256 channels, R8 restart
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd0, (32'd1 << 2) | 32'h2);
    expect_bins(0, 256, TD, "R5");
    pulse_start();
    check(done == 1'b0, "R8 start clears done", int'(done), 0);
    check(busy == 1'b1, "R8 start sets busy", int'(busy), 1);
    drain(3000, "R7");
    check(done == 1'b1, "R8 done after 256", int'(done), 1);
    repeat (20) @(negedge clk);
    icr_strobe = 1'b0;

    // R3 window inclusive, R4 other sources ignored
    wr_reg(2'd2, 32'd100);
    wr_reg(2'd1, (32'd20 << 16) | 32'd10);
    wr_reg(2'd0, 32'h1);
    q.push_back('{addr: 0, data: 3, req: "R3"});
    pulse_start();
    send_code(9); send_code(10); send_code(15); send_code(20); send_code(21);
    ttl_pulse(3, 3);
    @(negedge clk); icr_strobe = 1'b1; @(negedge clk); icr_strobe = 1'b0;
    drain(600, "R3");
    pulse_stop();
    idle_check("R11");
    repeat (450) @(negedge clk);

    // R3 upper below lower disables counting
    wr_reg(2'd1, (32'd10 << 16) | 32'd20);
    q.push_back('{addr: 0, data: 0, req: "R3"});
    pulse_start();
    send_code(10); send_code(15); send_code(20);
    drain(600, "R3");
    pulse_stop();

    // R2 pulse-line edges, held level counts once; R4 others ignored
    wr_reg(2'd1, (32'd20 << 16) | 32'd10);
    wr_reg(2'd0, 32'h0);
    q.push_back('{addr: 0, data: 4, req: "R2"});
    pulse_start();
    ttl_pulse(3, 3); ttl_pulse(3, 3); ttl_pulse(3, 3);
    ttl_pulse(50, 5);
    send_code(15);
    @(negedge clk); icr_strobe = 1'b1; @(negedge clk); icr_strobe = 1'b0;
    drain(600, "R2");
    pulse_stop();

    // R4 source code 3 counts nothing
    wr_reg(2'd2, 32'd20);
    wr_reg(2'd0, 32'h3);
    icr_strobe = 1'b1;
    q.push_back('{addr: 0, data: 0, req: "R4"});
    pulse_start();
    ttl_pulse(3, 3);
    send_code(15);
    drain(300, "R4");
    pulse_stop();

    // R10 saturation: 280 events into an 8-bit count
    wr_reg(2'd2, 32'd70);
    wr_reg(2'd0, 32'h2);
    q.push_back('{addr: 0, data: 255, req: "R10"});
    pulse_start();
    drain(600, "R10");
    pulse_stop();

    // R9 sweep wraps to 0, then R11 stop
    wr_reg(2'd2, 32'd2);
    wr_reg(2'd0, (32'd1 << 5) | 32'h2);
    expect_bins(0, 128, 2 * TD, "R9");
    expect_bins(0, 10, 2 * TD, "R9");
    pulse_start();
    drain(3000, "R9");
    pulse_stop();
    idle_check("R11");
    icr_strobe = 1'b0;
    repeat (40) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule